// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block receives configuration words over a three-wire serial link made of a data line, a serial clock and a load-enable line. Bits are shifted into a 21-bit shift register, most significant bit first. When load enable is raised, the upper 19 bits of the word are copied into one of four holding registers. The two bits sent last select which register receives them. Other logic on the chip reads the four registers as static settings. Each register has an update strobe that pulses once when that register takes a new value.

All three serial inputs are brought into the system clock domain through synchronizer stages, and their edges are detected there. This lets the whole block run on one clock with a synchronous active-low reset. An optional data-out pin shows the top bit of the shift register, updated on each falling edge of the serial clock. With that pin feeding the data input of a second device, several devices can share one chain. The serial clock must stay in each phase for at least four system clock cycles.

Top module: `scfg_loader`

## Requirements
- R1: After synchronous reset, all four holding registers and the shift register are zero, every update strobe is low and the data-out pin is low.
- R2: The data input is captured on each rising edge of the serial clock and shifted in most significant bit first, so the bit sent last lands in shift position 0.
- R3: Shift bits [1:0] form the target address: 00 writes register 0, 01 register 1, 10 register 2 and 11 register 3.
- R4: The value stored in the target register is shift bits [20:2], with shift bit 20 in stored bit 18; the address bits are not stored.
- R5: Each rising edge of load enable gives exactly one single-cycle update strobe, on the addressed register only, however long load enable stays high. The strobe is high in the first cycle in which the new value is visible.
- R6: A load changes only the addressed register; the other three keep their values.
- R7: Shifting while load enable is low leaves all holding registers unchanged.
- R8: When data-out mode is on, the data-out pin shows shift bit 20 as it was at the most recent falling edge of the serial clock. It changes only after such an edge, so a word comes out 21 serial clocks after it went in.
- R9: When data-out mode is off, the data-out pin stays low.
- R10: If more than 21 bits are shifted before a load, only the last 21 are kept; earlier bits are pushed out of the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to clk |
| ser_din | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load enable; its rising edge copies the payload into a register |
| dout_en | input | 1 | Data-out mode enable |
| dout | output | 1 | Serial data-out tap for chaining |
| cfg_q | output | 4 x 19 | The four holding registers, packed, register index as outer dimension |
| upd_stb | output | 4 | Per-register update strobe |

## Verification
Payloads of all ones, a single low bit, a single high bit and an alternating pattern go to each of the four addresses. A misrouted address, a reversed or shifted payload, or a swapped bit order therefore shows up as a distinct wrong value. The bench also loads the same shift content twice, holds load enable high for a long time, shifts a word without loading it, and shifts 25 bits for one word. These cases separate edge detection from level sensing, show that shifting does not reach the registers, and show that overflow bits are dropped. With data-out mode on, every bit on the data-out pin is compared against the word shifted in before. With the mode off, the pin is checked to stay low while ones are being shifted.

// File: rtl/scfg_pkg.sv
// Shared sizes and types for the serial configuration loader.
// Assumes a word holds a payload above a small address field in its low bits.
package scfg_pkg;
    localparam int WORD_W  = 21;
    localparam int ADDR_W  = 2;
    localparam int NREG    = 1 << ADDR_W;
    localparam int PAY_W   = WORD_W - ADDR_W;
    localparam int SYNC_N  = 2;

    typedef logic [PAY_W-1:0]  payload_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/scfg_sync.sv
// Multi-bit synchronizer chain: carries asynchronous level inputs into the clk
// domain through STAGES flops. Assumes each input bit is treated independently.
module scfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift each input through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
// Serial shift register with a data-out tap. Shifts on a rising edge of the
// synchronized serial clock and captures the top bit on a falling edge.
// Assumes clk_s and din_s passed through synchronizers of the same depth.
module scfg_shifter #(
    parameter int WORD_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_s,
    input  logic              din_s,
    input  logic              tap_en,
    output logic [WORD_W-1:0] word,
    output logic              dout
);
    logic clk_prev;
    logic rise_ev;
    logic fall_ev;
    logic tap_q;

    // Keep the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_s;
    end

    assign rise_ev =  clk_s && !clk_prev;
    assign fall_ev = !clk_s &&  clk_prev;

    // Shift the new bit into position 0 on each serial rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       word <= '0;
        else if (rise_ev) word <= {word[WORD_W-2:0], din_s};
    end

    // Capture the top shift bit on each serial falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       tap_q <= 1'b0;
        else if (fall_ev) tap_q <= word[WORD_W-1];
    end

    assign dout = tap_q && tap_en;
endmodule

// File: rtl/scfg_latch_bank.sv
// Bank of addressed holding registers with per-register update strobes.
// Detects the rising edge of synchronized load enable and writes the payload
// into the register picked by the address field. Assumes stable word on load.
module scfg_latch_bank #(
    parameter int ADDR_W = 2,
    parameter int PAY_W  = 19,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_s,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [PAY_W-1:0]           payload,
    output logic [NREG-1:0][PAY_W-1:0] cfg_q,
    output logic [NREG-1:0]            upd_stb
);
    logic            load_prev;
    logic            load_rise;
    logic [NREG-1:0] sel;

    // Keep the previous load level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) load_prev <= 1'b0;
        else        load_prev <= load_s;
    end

    assign load_rise = load_s && !load_prev;

    // Decode the address into a one-hot write select.
    always_comb begin
        sel = '0;
        if (load_rise) sel[addr] = 1'b1;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [PAY_W-1:0] val_r;
        logic             stb_r;

        // Hold one register's payload and pulse its strobe on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_r <= '0;
                stb_r <= 1'b0;
            end else begin
                stb_r <= sel[i];
                if (sel[i]) val_r <= payload;
            end
        end

        assign cfg_q[i]   = val_r;
        assign upd_stb[i] = stb_r;
    end
endmodule

// File: rtl/scfg_loader.sv
// Top of the serial configuration loader: synchronizes the three serial
// inputs, shifts words in and routes each payload to an addressed register.
// Assumes ser_clk stays in each phase for at least four clk cycles.
module scfg_loader #(
    parameter int WORD_W  = scfg_pkg::WORD_W,
    parameter int ADDR_W  = scfg_pkg::ADDR_W,
    parameter int SYNC_N  = scfg_pkg::SYNC_N,
    localparam int NREG   = 1 << ADDR_W,
    localparam int PAY_W  = WORD_W - ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk,
    input  logic                       ser_din,
    input  logic                       ser_load,
    input  logic                       dout_en,
    output logic                       dout,
    output logic [NREG-1:0][PAY_W-1:0] cfg_q,
    output logic [NREG-1:0]            upd_stb
);
    logic [2:0]        sync_q;
    logic [WORD_W-1:0] word;

    scfg_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_load, ser_din, ser_clk}),
        .q     (sync_q)
    );

    scfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_s  (sync_q[0]),
        .din_s  (sync_q[1]),
        .tap_en (dout_en),
        .word   (word),
        .dout   (dout)
    );

    scfg_latch_bank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_s  (sync_q[2]),
        .addr    (word[ADDR_W-1:0]),
        .payload (word[WORD_W-1:ADDR_W]),
        .cfg_q   (cfg_q),
        .upd_stb (upd_stb)
    );
endmodule

// File: rtl/scfg_loader_chk.sv
// Property checker for scfg_loader, attached with bind.
module scfg_loader_chk #(
    parameter int NREG  = 4,
    parameter int PAY_W = 19
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ser_clk,
    input logic                       ser_load,
    input logic                       dout_en,
    input logic                       dout,
    input logic [NREG-1:0][PAY_W-1:0] cfg_q,
    input logic [NREG-1:0]            upd_stb
);
    // R5
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_stb));

    // R5
    stb_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb) |-> $past(ser_load, 3));

    // R8
    dout_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en) && dout != $past(dout)) |-> !$past(ser_clk, 3));

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        // R5
        stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd_stb[i] |=> !upd_stb[i]);

        // R6
        reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[i] != $past(cfg_q[i])) |-> upd_stb[i]);
    end
endmodule

bind scfg_loader scfg_loader_chk #(.NREG(NREG), .PAY_W(PAY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_load (ser_load),
    .dout_en  (dout_en),
    .dout     (dout),
    .cfg_q    (cfg_q),
    .upd_stb  (upd_stb)
);

// File: tb/sim_scfg_loader.sv
// Scoreboard bench: the driver queues expected writes, the monitor checks them.
module sim_scfg_loader;
    localparam int WW = 21;
    localparam int AW = 2;
    localparam int NR = 4;
    localparam int PW = 19;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_load = 1'b0;
    logic dout_en = 1'b0;
    logic dout;
    logic [NR-1:0][PW-1:0] cfg_q;
    logic [NR-1:0] upd_stb;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    int loads = 0;
    bit done = 0;

    logic [WW-1:0] bsh = '0;
    logic [PW-1:0] model [NR];
    logic [WW-1:0] expq [$];

    always #2.5 clk = ~clk;

    scfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load(ser_load), .dout_en(dout_en), .dout(dout),
        .cfg_q(cfg_q), .upd_stb(upd_stb)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift n bits of v, MSB first, checking the data-out pin each low phase.
    task automatic send_bits(input int n, input logic [31:0] v);
        for (int k = n - 1; k >= 0; k--) begin
            ser_din = v[k];
            ser_clk = 1'b0;
            wait_cyc(HALF);
            if (dout_en) chk(dout == bsh[WW-1], "R8 dout", dout, bsh[WW-1]);
            else         chk(dout == 1'b0, "R9 dout", dout, 0);
            ser_clk = 1'b1;
            wait_cyc(HALF);
            bsh = {bsh[WW-2:0], v[k]};
        end
        ser_clk = 1'b0;
        wait_cyc(HALF);
    endtask

    // Compare all four registers with the model.
    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++)
            chk(cfg_q[i] == model[i], req, cfg_q[i], model[i]);
    endtask

    // Pulse load enable, queue the expected write and check every register.
    task automatic do_load(input int width);
        expq.push_back(bsh);
        model[bsh[AW-1:0]] = bsh[WW-1:AW];
        loads++;
        ser_load = 1'b1;
        wait_cyc(width);
        ser_load = 1'b0;
        wait_cyc(HALF);
        check_regs("R6 other regs held");
    endtask

    task automatic send_word(input logic [PW-1:0] pay, input logic [AW-1:0] a,
                             input int width);
        send_bits(WW, {11'b0, pay, a});
        do_load(width);
    endtask

    // Monitor: pop an expected write on each strobe and compare.
    always @(negedge clk) begin
        if (rst_n && |upd_stb) begin
            logic [WW-1:0] e;
            strobes++;
            if (expq.size() == 0) begin
                chk(0, "R5 unexpected strobe", upd_stb, 0);
            end else begin
                e = expq.pop_front();
                // R3: strobe on the addressed register only
                chk(upd_stb == (4'b1 << e[AW-1:0]), "R3 strobe select",
                    upd_stb, 4'b1 << e[AW-1:0]);
                // R4 / R2: payload value is bits [20:2], visible with the strobe
                chk(cfg_q[e[AW-1:0]] == e[WW-1:AW], "R4 payload",
                    cfg_q[e[AW-1:0]], e[WW-1:AW]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        wait_cyc(10);
        // R1: reset state
        check_regs("R1 reset regs");
        chk(upd_stb == '0, "R1 reset strobes", upd_stb, 0);
        chk(dout == 1'b0, "R1 reset dout", dout, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        dout_en = 1'b1;

        // R2 R3 R4: each address, distinct payloads
        send_word(19'h5A5A5, 2'd0, HALF);
        send_word(19'h7FFFF, 2'd1, HALF);
        send_word(19'h00001, 2'd2, HALF);
        send_word(19'h40000, 2'd3, HALF);
        // R5: long load pulse gives one strobe
        send_word(19'h7FFFE, 2'd2, 60);
        chk(strobes == loads, "R5 strobe count long pulse", strobes, loads);

        // R7: shift without load leaves registers unchanged
        send_bits(WW, {11'b0, 19'h2AAAA, 2'd1});
        check_regs("R7 shift no load");
        chk(strobes == loads, "R7 no strobe", strobes, loads);
        do_load(HALF);

        // R5: reload same content twice, one strobe each
        do_load(HALF);
        chk(strobes == loads, "R5 strobe per pulse", strobes, loads);

        // R10: 25 bits shifted, only the last 21 kept
        send_bits(25, {7'b0, 4'b1011, 19'h13579, 2'd3});
        chk(bsh[WW-1:AW] == 19'h13579, "R10 bench model", bsh[WW-1:AW], 19'h13579);
        do_load(HALF);
        chk(cfg_q[3] == 19'h13579, "R10 overflow dropped", cfg_q[3], 19'h13579);

        // R9: data-out off while shifting ones
        dout_en = 1'b0;
        send_word(19'h7FFFF, 2'd0, HALF);
        chk(dout == 1'b0, "R9 dout off", dout, 0);
        dout_en = 1'b1;
        // R8: chained readout of the previous word
        send_word(19'h0F0F0, 2'd1, HALF);

        chk(strobes == loads, "R5 total strobes", strobes, loads);
        chk(expq.size() == 0, "R5 queue drained", expq.size(), 0);

        // R1: reset during operation clears everything
        rst_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < NR; i++) model[i] = '0;
        check_regs("R1 reset again");
        chk(dout == 1'b0, "R1 dout after reset", dout, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule